// File: doc/BRIEF.md
# CAN Transmit Fault Confinement and Interrupt Logic

This block keeps the transmit side of a CAN controller's fault confinement. A protocol engine reports each failed transmission and each successful one as a single-cycle pulse. The block turns these pulses into a transmit error count. From that count it derives a warning indication and the error-active, error-passive and bus-off confinement states. Once the node is bus-off, only an explicit recovery request brings it back.

The block also tracks three transmit buffers. Software may load a buffer and later request its transmission. A success pulse tagged with the buffer number frees that buffer again. Each buffer drives a level flag that is high while the buffer is free to take a new message.

Error conditions are latched into a 16-bit interrupt status word. The transmit conditions come from inside the block and the receive conditions come from a level input. Each status bit is set on the rising edge of its condition and stays set until software writes a one to it. A single error interrupt line is the OR of all error bits in that word.

Top module: `can_tx_fault_conf`

## Requirements
- R1: After synchronous reset the counter reads 0, the warning, passive and bus-off flags are 0, all three buffer-free flags are 1, and the status word and error interrupt are 0.
- R2: While not bus-off, a transmit error pulse adds 8 to the counter and a success pulse subtracts 1, never going below 0. Both pulses in the same cycle give a net change of +7, and a success pulse at 0 with no error keeps 0.
- R3: The warning flag is 1 exactly when the counter is 96 or more.
- R4: The passive flag is 1 while the counter is above 127 and the node is not bus-off. It returns to 0 once the counter is 127 or less.
- R5: If an error would take the count above 255, the node enters bus-off and the counter reads 255. A count of exactly 255 is not yet bus-off. While bus-off, error and success pulses change neither the counter nor the buffers.
- R6: A recovery request while bus-off sets the counter to 0 and the state to error-active in one cycle. Outside bus-off, a recovery request has no effect.
- R7: Buffer n is numbered 0 to 2, and a success pulse carries n as a 2-bit binary index. A load or request strobe on a free buffer clears its free flag. A request marks the buffer scheduled. A success pulse with index n frees buffer n only if it is scheduled; a success pulse to a loaded but unscheduled buffer is ignored.
- R8: While bus-off, request strobes are ignored.
- R9: Status bits are: 8 receive warning, 9 transmit warning, 10 receive passive, 11 receive bus-off, 12 transmit passive, 13 transmit bus-off. The receive input carries bit 0 warning, bit 1 passive and bit 2 bus-off. A status bit is set at the clock edge after its condition rises, and it stays set after the condition clears.
- R10: A status write clears each bit written as 1 and leaves bits written as 0 untouched. A condition rising in the same cycle as the clear wins. A clear while the condition is still high does not re-set the bit.
- R11: The error interrupt is 1 exactly when any of status bits 8 to 13 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_pulse | input | 1 | One-cycle pulse: a transmission failed |
| tx_ok_pulse | input | 1 | One-cycle pulse: a transmission succeeded |
| tx_ok_buf | input | 2 | Buffer index that goes with tx_ok_pulse |
| buf_load | input | 3 | Per-buffer load strobe |
| buf_req | input | 3 | Per-buffer transmit request strobe |
| recover_req | input | 1 | Bus-off recovery request |
| rx_cond | input | 3 | Receive levels: bit0 warning, bit1 passive, bit2 bus-off |
| stat_wr | input | 1 | Write strobe for write-one-to-clear |
| stat_wdata | input | 16 | Bits to clear in the status word |
| tec | output | 8 | Transmit error counter |
| tx_warn | output | 1 | Counter at or above the warning limit |
| tx_passive | output | 1 | Error-passive state |
| tx_busoff | output | 1 | Bus-off state |
| buf_free | output | 3 | Per-buffer free flag (transmit-available interrupt) |
| err_irq | output | 1 | Combined error interrupt |
| int_status | output | 16 | Sticky interrupt status word |

## Verification
The counter, the three state flags and the buffer-free flags change at the first clock edge after the pulse or strobe is driven. A status bit and the error interrupt follow one edge later, because the capture compares the condition against its value from the previous cycle. The bench drives every stimulus on the falling edge and samples on the falling edge that follows. For status bits it first checks that the bit is still clear at that point, then takes one more cycle before checking that it is set. A reference count and state are kept in the bench and updated alongside every pulse.

// File: rtl/txfc_pkg.sv
package txfc_pkg;
    localparam int TEC_W  = 8;
    localparam int STAT_W = 16;
    localparam int NRX    = 3;

    localparam int BIT_RX_WARN = 8;
    localparam int BIT_TX_WARN = 9;
    localparam int BIT_RX_PASS = 10;
    localparam int BIT_RX_BOFF = 11;
    localparam int BIT_TX_PASS = 12;
    localparam int BIT_TX_BOFF = 13;

    localparam logic [STAT_W-1:0] ERR_MASK =
        (STAT_W'(1) << BIT_RX_WARN) | (STAT_W'(1) << BIT_TX_WARN) |
        (STAT_W'(1) << BIT_RX_PASS) | (STAT_W'(1) << BIT_RX_BOFF) |
        (STAT_W'(1) << BIT_TX_PASS) | (STAT_W'(1) << BIT_TX_BOFF);

    typedef enum logic [1:0] {
        CONF_ACTIVE  = 2'd0,
        CONF_PASSIVE = 2'd1,
        CONF_BUSOFF  = 2'd2
    } conf_state_e;

    typedef enum logic [1:0] {
        BUF_EMPTY  = 2'd0,
        BUF_LOADED = 2'd1,
        BUF_SCHED  = 2'd2
    } buf_state_e;

    typedef struct packed {
        logic err;
        logic ok;
        logic recover;
    } tec_evt_t;

    // One step of the counter, one bit wider so an overflow is visible.
    function automatic logic [TEC_W:0] tec_next(input logic [TEC_W-1:0] cur,
                                               input tec_evt_t ev,
                                               input logic [TEC_W-1:0] step);
        logic [TEC_W:0] s;
        s = {1'b0, cur} + (ev.err ? {1'b0, step} : '0);
        if (ev.ok && (s != '0))
            s = s - 1'b1;
        return s;
    endfunction
endpackage

// File: rtl/txfc_err_counter.sv
module txfc_err_counter
    import txfc_pkg::*;
#(
    parameter int ERR_STEP = 8,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 127
) (
    input  logic             clk,
    input  logic             rst,
    input  tec_evt_t         ev,
    output logic [TEC_W-1:0] tec,
    output conf_state_e      state,
    output logic             warn
);
    localparam logic [TEC_W:0]   TOP_V  = (TEC_W+1)'((1 << TEC_W) - 1);
    localparam logic [TEC_W:0]   PASS_V = (TEC_W+1)'(PASS_LIM);
    localparam logic [TEC_W-1:0] WARN_V = TEC_W'(WARN_LIM);
    localparam logic [TEC_W-1:0] STEP_V = TEC_W'(ERR_STEP);

    logic [TEC_W-1:0] tec_q;
    conf_state_e      st_q;
    logic [TEC_W:0]   sum;

    always_comb sum = tec_next(tec_q, ev, STEP_V);

    always_ff @(posedge clk) begin
        if (rst) begin
            tec_q <= '0;
            st_q  <= CONF_ACTIVE;
        end else if (st_q == CONF_BUSOFF) begin
            if (ev.recover) begin
                tec_q <= '0;
                st_q  <= CONF_ACTIVE;
            end
        end else if (sum > TOP_V) begin
            tec_q <= '1;
            st_q  <= CONF_BUSOFF;
        end else begin
            tec_q <= sum[TEC_W-1:0];
            st_q  <= (sum > PASS_V) ? CONF_PASSIVE : CONF_ACTIVE;
        end
    end

    assign tec   = tec_q;
    assign state = st_q;
    assign warn  = (tec_q >= WARN_V);
endmodule

// File: rtl/txfc_buf_tracker.sv
module txfc_buf_tracker
    import txfc_pkg::*;
#(
    parameter int NB = 3,
    localparam int IDXW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NB-1:0]   load,
    input  logic [NB-1:0]   req,
    input  logic            ok,
    input  logic [IDXW-1:0] ok_idx,
    input  logic            block,
    output logic [NB-1:0]   free
);
    for (genvar i = 0; i < NB; i++) begin : g_buf
        buf_state_e st;
        logic       hit;

        assign hit = ok && (ok_idx == IDXW'(i));

        always_ff @(posedge clk) begin
            if (rst)
                st <= BUF_EMPTY;
            else if (req[i] && !block)
                st <= BUF_SCHED;
            else if (hit && st == BUF_SCHED)
                st <= BUF_EMPTY;
            else if (load[i] && st == BUF_EMPTY)
                st <= BUF_LOADED;
        end

        assign free[i] = (st == BUF_EMPTY);
    end
endmodule

// File: rtl/txfc_status_reg.sv
module txfc_status_reg
    import txfc_pkg::*;
#(
    parameter int               W    = STAT_W,
    parameter logic [W-1:0]     MASK = ERR_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cond,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] stat,
    output logic         any_err
);
    logic [W-1:0] prev_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr;

    always_comb begin
        rise = cond & ~prev_q & MASK;
        clr  = clr_we ? clr_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= cond & MASK;
            stat_q <= (stat_q & ~clr) | rise;
        end
    end

    assign stat    = stat_q;
    assign any_err = |(stat_q & MASK);
endmodule

// File: rtl/can_tx_fault_conf.sv
module can_tx_fault_conf
    import txfc_pkg::*;
#(
    parameter int NBUF     = 3,
    parameter int ERR_STEP = 8,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 127
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tx_err_pulse,
    input  logic                    tx_ok_pulse,
    input  logic [$clog2(NBUF)-1:0] tx_ok_buf,
    input  logic [NBUF-1:0]         buf_load,
    input  logic [NBUF-1:0]         buf_req,
    input  logic                    recover_req,
    input  logic [NRX-1:0]          rx_cond,
    input  logic                    stat_wr,
    input  logic [STAT_W-1:0]       stat_wdata,
    output logic [TEC_W-1:0]        tec,
    output logic                    tx_warn,
    output logic                    tx_passive,
    output logic                    tx_busoff,
    output logic [NBUF-1:0]         buf_free,
    output logic                    err_irq,
    output logic [STAT_W-1:0]       int_status
);
    tec_evt_t          ev;
    conf_state_e       state;
    logic [STAT_W-1:0] cond;
    logic              ok_live;

    assign ok_live    = tx_ok_pulse && !tx_busoff;
    assign ev         = '{err: tx_err_pulse, ok: tx_ok_pulse, recover: recover_req};
    assign tx_passive = (state == CONF_PASSIVE);
    assign tx_busoff  = (state == CONF_BUSOFF);

    txfc_err_counter #(
        .ERR_STEP (ERR_STEP),
        .WARN_LIM (WARN_LIM),
        .PASS_LIM (PASS_LIM)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .tec   (tec),
        .state (state),
        .warn  (tx_warn)
    );

    txfc_buf_tracker #(.NB(NBUF)) u_bufs (
        .clk    (clk),
        .rst    (rst),
        .load   (buf_load),
        .req    (buf_req),
        .ok     (ok_live),
        .ok_idx (tx_ok_buf),
        .block  (tx_busoff),
        .free   (buf_free)
    );

    always_comb begin
        cond              = '0;
        cond[BIT_RX_WARN] = rx_cond[0];
        cond[BIT_RX_PASS] = rx_cond[1];
        cond[BIT_RX_BOFF] = rx_cond[2];
        cond[BIT_TX_WARN] = tx_warn;
        cond[BIT_TX_PASS] = tx_passive;
        cond[BIT_TX_BOFF] = tx_busoff;
    end

    txfc_status_reg #(.W(STAT_W), .MASK(ERR_MASK)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .cond     (cond),
        .clr_we   (stat_wr),
        .clr_data (stat_wdata),
        .stat     (int_status),
        .any_err  (err_irq)
    );
endmodule

// File: rtl/txfc_checker.sv
module txfc_checker (
    input logic        clk,
    input logic        rst,
    input logic        tx_err_pulse,
    input logic        tx_ok_pulse,
    input logic [2:0]  buf_req,
    input logic        recover_req,
    input logic [7:0]  tec,
    input logic        tx_warn,
    input logic        tx_passive,
    input logic        tx_busoff,
    input logic [2:0]  buf_free,
    input logic [15:0] int_status
);
    // R2: a lone error outside bus-off adds eight
    assert_err_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_err_pulse && !tx_ok_pulse && !tx_busoff && tec <= 8'd247)
        |=> (tec == 8'($past(tec) + 8'd8)));

    // R2: a lone success at zero stays at zero
    assert_floor_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_ok_pulse && !tx_err_pulse && !tx_busoff && tec == 8'd0) |=> (tec == 8'd0));

    // R4 and R5: the confinement states never overlap
    assert_state_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(tx_passive && tx_busoff));

    // R5: bus-off holds at full count until recovery
    assert_busoff_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_busoff && !recover_req) |=> (tx_busoff && tec == 8'hFF && tx_warn));

    // R6: recovery returns to error-active with an empty counter
    assert_recover_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_busoff && recover_req) |=> (tec == 8'd0 && !tx_busoff && !tx_passive));

    // R7: a granted request takes the buffer out of the free set
    assert_req_clears_R7: assert property (@(posedge clk) disable iff (rst)
        ((|buf_req) && !tx_busoff) |=> ((buf_free & $past(buf_req)) == 3'b000));

    // R8: requests during bus-off leave the free flags alone
    assert_req_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        ((|buf_req) && tx_busoff && !tx_ok_pulse) |=> (buf_free == $past(buf_free)));

    // R9: entering error-passive is latched one edge later
    assert_pass_capture_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_passive) |=> int_status[12]);
endmodule

bind can_tx_fault_conf txfc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_err_pulse (tx_err_pulse),
    .tx_ok_pulse  (tx_ok_pulse),
    .buf_req      (buf_req),
    .recover_req  (recover_req),
    .tec          (tec),
    .tx_warn      (tx_warn),
    .tx_passive   (tx_passive),
    .tx_busoff    (tx_busoff),
    .buf_free     (buf_free),
    .int_status   (int_status)
);

// File: tb/sim_can_tx_fault_conf.sv
`timescale 1ns/1ps
module sim_can_tx_fault_conf;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_err_pulse = 1'b0;
    logic        tx_ok_pulse = 1'b0;
    logic [1:0]  tx_ok_buf = 2'd0;
    logic [2:0]  buf_load = 3'b000;
    logic [2:0]  buf_req = 3'b000;
    logic        recover_req = 1'b0;
    logic [2:0]  rx_cond = 3'b000;
    logic        stat_wr = 1'b0;
    logic [15:0] stat_wdata = 16'h0;
    logic [7:0]  tec;
    logic        tx_warn, tx_passive, tx_busoff, err_irq;
    logic [2:0]  buf_free;
    logic [15:0] int_status;

    int n_chk = 0;
    int n_bad = 0;
    int m_tec = 0;
    bit m_boff = 1'b0;

    always #2.5 clk = ~clk;

    can_tx_fault_conf u0 (
        .clk(clk), .rst(rst), .tx_err_pulse(tx_err_pulse), .tx_ok_pulse(tx_ok_pulse),
        .tx_ok_buf(tx_ok_buf), .buf_load(buf_load), .buf_req(buf_req),
        .recover_req(recover_req), .rx_cond(rx_cond), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .tec(tec), .tx_warn(tx_warn), .tx_passive(tx_passive),
        .tx_busoff(tx_busoff), .buf_free(buf_free), .err_irq(err_irq),
        .int_status(int_status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_ctr(input string tag);
        chk({tag, " tec"}, 32'(tec), 32'(m_tec));
        chk({tag, " warn (R3)"}, 32'(tx_warn), 32'(m_tec >= 96));
        chk({tag, " passive (R4)"}, 32'(tx_passive), 32'(m_tec > 127 && !m_boff));
        chk({tag, " busoff (R5)"}, 32'(tx_busoff), 32'(m_boff));
    endtask

    task automatic pulse_err(input int n);
        for (int k = 0; k < n; k++) begin
            tx_err_pulse = 1'b1;
            step();
            tx_err_pulse = 1'b0;
            if (!m_boff) begin
                if (m_tec + 8 > 255) begin m_boff = 1'b1; m_tec = 255; end
                else m_tec = m_tec + 8;
            end
        end
    endtask

    task automatic pulse_ok(input int n);
        for (int k = 0; k < n; k++) begin
            tx_ok_pulse = 1'b1;
            step();
            tx_ok_pulse = 1'b0;
            if (!m_boff && m_tec > 0) m_tec = m_tec - 1;
        end
    endtask

    task automatic clear_stat(input logic [15:0] bits);
        stat_wr = 1'b1;
        stat_wdata = bits;
        step();
        stat_wr = 1'b0;
        stat_wdata = 16'h0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        chk("R1 tec", 32'(tec), 0);
        chk("R1 flags", 32'({tx_warn, tx_passive, tx_busoff}), 0);
        chk("R1 buf_free", 32'(buf_free), 32'h7);
        chk("R1 status", 32'(int_status), 0);
        chk("R1 err_irq", 32'(err_irq), 0);
    endtask

    task automatic t_buffers();
        buf_load = 3'b001; step(); buf_load = 3'b000;
        chk("R7 load clears free", 32'(buf_free), 32'h6);
        buf_req = 3'b010; step(); buf_req = 3'b000;
        chk("R7 request clears free", 32'(buf_free), 32'h4);
        tx_ok_buf = 2'd1; tx_ok_pulse = 1'b1; step(); tx_ok_pulse = 1'b0;
        chk("R7 success frees scheduled", 32'(buf_free), 32'h6);
        tx_ok_buf = 2'd0; tx_ok_pulse = 1'b1; step(); tx_ok_pulse = 1'b0;
        chk("R7 success on loaded ignored", 32'(buf_free), 32'h6);
        buf_req = 3'b001; step(); buf_req = 3'b000;
        tx_ok_buf = 2'd0; tx_ok_pulse = 1'b1; step(); tx_ok_pulse = 1'b0;
        chk("R7 loaded then scheduled then freed", 32'(buf_free), 32'h7);
        buf_req = 3'b010; step(); buf_req = 3'b000;
        chk("R7 buffer 1 scheduled again", 32'(buf_free), 32'h5);
        tx_ok_buf = 2'd2; tx_ok_pulse = 1'b1; step(); tx_ok_pulse = 1'b0;
        chk("R7 success to free buffer 2 ignored", 32'(buf_free), 32'h5);
        // the pulses above decremented nothing from zero
        chk_ctr("R2 floor after buffer traffic");
    endtask

    task automatic t_counting();
        tx_ok_buf = 2'd0;
        pulse_err(3);
        chk_ctr("R2 three errors");
        chk("R2 value 24", 32'(tec), 24);
        pulse_ok(2);
        chk("R2 two successes", 32'(tec), 22);
        tx_err_pulse = 1'b1; tx_ok_pulse = 1'b1; step();
        tx_err_pulse = 1'b0; tx_ok_pulse = 1'b0;
        m_tec = m_tec + 7;
        chk("R2 both pulses net +7", 32'(tec), 29);
        recover_req = 1'b1; step(); recover_req = 1'b0;
        chk("R6 recovery outside bus-off ignored", 32'(tec), 29);
        pulse_ok(31);
        chk("R2 floor at zero", 32'(tec), 0);
        chk_ctr("R2 after drain");
    endtask

    task automatic t_thresholds();
        pulse_err(11);
        chk_ctr("R3 at 88");
        pulse_err(1);
        chk_ctr("R3 at 96");
        chk("R9 warn bit not yet latched", 32'(int_status[9]), 0);
        step();
        chk("R9 warn bit latched", 32'(int_status[9]), 1);
        chk("R11 irq with warn bit", 32'(err_irq), 1);
        pulse_err(4);
        chk_ctr("R4 at 128");
        chk("R9 passive bit not yet latched", 32'(int_status[12]), 0);
        step();
        chk("R9 passive bit latched", 32'(int_status[12]), 1);
        pulse_ok(1);
        chk_ctr("R4 back to 127");
        chk("R9 passive bit sticky", 32'(int_status[12]), 1);
        pulse_err(1);
        chk_ctr("R4 passive again at 135");
    endtask

    task automatic t_w1c();
        clear_stat(16'h0000);
        chk("R10 zero write keeps bits", 32'(int_status), 32'h1200);
        clear_stat(16'h0200);
        chk("R10 clear warn bit only", 32'(int_status), 32'h1000);
        clear_stat(16'h1000);
        chk("R10 cleared while condition high", 32'(int_status), 0);
        step();
        chk("R10 no re-set while condition held", 32'(int_status), 0);
        chk("R11 irq low with no bits", 32'(err_irq), 0);
    endtask

    task automatic t_busoff();
        pulse_err(15);
        chk_ctr("R5 at 255 not bus-off");
        pulse_err(1);
        chk_ctr("R5 entered bus-off");
        // condition rose at the last edge; clear it in the capturing cycle
        clear_stat(16'h2000);
        chk("R10 set wins over clear", 32'(int_status[13]), 1);
        pulse_err(2);
        pulse_ok(2);
        chk_ctr("R5 pulses ignored in bus-off");
        buf_req = 3'b100; step(); buf_req = 3'b000;
        chk("R8 request ignored in bus-off", 32'(buf_free), 32'h5);
        tx_ok_buf = 2'd1; tx_ok_pulse = 1'b1; step(); tx_ok_pulse = 1'b0;
        chk("R5 success ignored by buffers in bus-off", 32'(buf_free), 32'h5);
        recover_req = 1'b1; step(); recover_req = 1'b0;
        m_boff = 1'b0; m_tec = 0;
        chk_ctr("R6 recovered");
        tx_ok_buf = 2'd1; tx_ok_pulse = 1'b1; step(); tx_ok_pulse = 1'b0;
        chk("R7 release after recovery", 32'(buf_free), 32'h7);
        clear_stat(16'hFFFF);
        chk("R10 all cleared", 32'(int_status), 0);
    endtask

    task automatic t_rx();
        rx_cond = 3'b010; step();
        chk("R9 rx passive on bit 10", 32'(int_status), 32'h0400);
        chk("R11 irq from rx bit", 32'(err_irq), 1);
        rx_cond = 3'b101; step();
        chk("R9 rx warn and bus-off on bits 8 and 11", 32'(int_status), 32'h0D00);
        rx_cond = 3'b000; step();
        chk("R9 rx bits sticky", 32'(int_status), 32'h0D00);
        clear_stat(16'h0D00);
        chk("R11 irq drops", 32'(err_irq), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_buffers();
        t_counting();
        t_thresholds();
        t_w1c();
        t_busoff();
        t_rx();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule